// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block is a host-side controller for a two-channel serial current-output converter. The converter is reached over a chip-select, serial-clock and serial-data link, plus an active-low load strobe. A request carries a value for channel A, a value for channel B and a two-bit mode. The sequencer turns the request into address-plus-data frames, drives them onto the link, and works the load strobe so that the converter outputs change either one at a time or both in the same instant.

All link timing is derived from the system clock. The serial clock half-period, the quiet time after chip select rises, the spacing between frames and the strobe width are parameters counted in system cycles. A request is taken through a valid/ready handshake. When the last frame or strobe of a request is finished, the block raises `done` for one cycle.

Mode encoding: bit 0 set selects immediate update, with the load strobe held low for the whole transaction. Bit 0 clear selects double-buffered update, which ends in one strobe pulse. Bit 1 set selects broadcast, which sends a single frame to both channels. Bit 1 clear sends a channel A frame and then a channel B frame.

Top module: `dacpair_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a request is accepted, chip select is high, the serial clock is low, the load strobe is high, `req_ready` is high and `done` is low. An asynchronous reset in the middle of a transaction returns all of these at once.
- R2: Each frame holds chip select low for exactly ADDR_W+DATA_W (18) rising serial clock edges. The frame carries a 2-bit address first and then the data, most significant bit first. Address 01 selects channel A, address 10 selects channel B and address 11 selects both channels.
- R3: Each serial clock high phase and low phase lasts at least HALF_CYC system cycles. Serial data changes only while the serial clock is low, and it is stable for at least HALF_CYC cycles before each rising edge.
- R4: The serial clock is low in the cycle of every chip-select transition and in the cycle before it.
- R5: Mode 00 sends a channel A frame and then a channel B frame, with the load strobe high at each chip-select rise. It then gives exactly one low strobe pulse, so that both converter outputs change in the same cycle.
- R6: Mode 01 holds the load strobe low from the start of the first frame until after the last frame. Channel A updates at the end of its own frame, before channel B updates, and no separate strobe pulse follows.
- R7: With mode bit 1 set, exactly one frame with address 11 carries the channel A value, and the channel B value has no effect. A strobe pulse follows only when bit 0 is clear.
- R8: The strobe pulse stays low for at least STRB_CYC cycles. It starts at least TAIL_CYC cycles after chip select rises, and it returns high only while chip select is high.
- R9: Between the two frames of a request, chip select stays high for at least TAIL_CYC+GAP_CYC cycles.
- R10: `req_ready` is high only while the block is idle, and it is low whenever chip select is low. A request is taken on a cycle with valid and ready both high. A request held valid while the block is busy has no effect on the frames in progress.
- R11: `done` is a single-cycle pulse, given exactly once per accepted request after its final frame or strobe, and `req_ready` is low during that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 2 | Bit 0 immediate, bit 1 broadcast |
| req_data_a | input | DATA_W | Channel A value (broadcast value) |
| req_data_b | input | DATA_W | Channel B value |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, converter samples on rise |
| dac_sdi | output | 1 | Serial data |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
The bench decodes every frame from the pins into a model of the converter's input and output registers. It records the cycle in which each output changes. If the strobe were issued before the B frame, or the strobe were left low in double-buffered mode, the two outputs would change in different cycles, and the bench catches this. An off-by-one bit counter shows up as 17 or 19 clocks per frame, and a shift in the wrong direction shows up as a mismatched frame value. Serial data changing at the rising edge, or a serial clock moving at a chip-select edge, is caught by the phase, setup and idle measurements. The bench also keeps a request valid while the block is busy and resets in the middle of a frame. A design that latched requests while busy, or recovered only partly from reset, would emit extra or corrupted frames.

// File: rtl/dacpair_pkg.sv
package dacpair_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] ADDR_CH_A  = 2'b01;
   localparam logic [ADDR_W-1:0] ADDR_CH_B  = 2'b10;
   localparam logic [ADDR_W-1:0] ADDR_BOTH  = 2'b11;
   localparam int MODE_IMM_BIT   = 0;
   localparam int MODE_BCAST_BIT = 1;

   typedef enum logic [2:0] {
      S_IDLE, S_FRAME_A, S_GAP, S_FRAME_B, S_STROBE, S_DONE
   } seq_state_t;

   typedef enum logic [2:0] {
      TX_IDLE, TX_LOW, TX_HIGH, TX_END, TX_TAIL
   } tx_state_t;
endpackage

// File: rtl/dacpair_countdown.sv
module dacpair_countdown #(
   parameter int MAX_LEN = 2,
   localparam int CW = $clog2(MAX_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   generate
      if (MAX_LEN <= 1) begin : g_trivial
         logic unused_bits;
         assign unused_bits = load ^ (|load_val) ^ clk ^ rst_n;
         assign expired = 1'b1;
      end else begin : g_counter
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (load)          cnt <= load_val;
            else if (cnt != '0)     cnt <= cnt - 1'b1;
         end
         assign expired = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/dacpair_frame_tx.sv
module dacpair_frame_tx
   import dacpair_pkg::*;
#(
   parameter int FRAME_W  = 18,
   parameter int HALF_CYC = 2,
   parameter int TAIL_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               fin,
   output logic               cs_n,
   output logic               sclk,
   output logic               sdi
);
   localparam int WAIT_MAX = (HALF_CYC > TAIL_CYC) ? HALF_CYC : TAIL_CYC;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);
   localparam int BIT_W    = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);

   tx_state_t          st;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bits_left;
   logic [FRAME_W-1:0] shreg;
   logic               phase_end;

   assign phase_end = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= TX_IDLE;
         cnt       <= '0;
         bits_left <= '0;
         shreg     <= '0;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         sdi       <= 1'b0;
         fin       <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            TX_IDLE: if (start) begin
               shreg     <= frame;
               sdi       <= frame[FRAME_W-1];
               bits_left <= BIT_W'(FRAME_W);
               cs_n      <= 1'b0;
               cnt       <= HALF_LD;
               st        <= TX_LOW;
            end
            TX_LOW: if (phase_end) begin
               sclk <= 1'b1;
               cnt  <= HALF_LD;
               st   <= TX_HIGH;
            end else cnt <= cnt - 1'b1;
            TX_HIGH: if (phase_end) begin
               sclk      <= 1'b0;
               cnt       <= HALF_LD;
               bits_left <= bits_left - 1'b1;
               if (bits_left == BIT_W'(1)) begin
                  st <= TX_END;
               end else begin
                  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  sdi   <= shreg[FRAME_W-2];
                  st    <= TX_LOW;
               end
            end else cnt <= cnt - 1'b1;
            TX_END: if (phase_end) begin
               cs_n <= 1'b1;
               cnt  <= TAIL_LD;
               st   <= TX_TAIL;
            end else cnt <= cnt - 1'b1;
            TX_TAIL: if (phase_end) begin
               fin <= 1'b1;
               st  <= TX_IDLE;
            end else cnt <= cnt - 1'b1;
            default: st <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dacpair_seq.sv
module dacpair_seq
   import dacpair_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALF_CYC = 2,
   parameter int TAIL_CYC = 2,
   parameter int GAP_CYC  = 2,
   parameter int STRB_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_mode,
   input  logic [DATA_W-1:0] req_data_a,
   input  logic [DATA_W-1:0] req_data_b,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_ldac_n
);
   localparam int FRAME_W  = ADDR_W + DATA_W;
   localparam int WAIT_MAX = (GAP_CYC > STRB_CYC) ? GAP_CYC : STRB_CYC;
   localparam int WCNT_W   = $clog2(WAIT_MAX + 1);
   localparam logic [WCNT_W-1:0] GAP_LD  = WCNT_W'(GAP_CYC - 1);
   localparam logic [WCNT_W-1:0] STRB_LD = WCNT_W'(STRB_CYC - 1);

   generate
      if (DATA_W < 2)   begin : g_bad_data  $error("DATA_W must be at least 2");   end
      if (HALF_CYC < 1) begin : g_bad_half  $error("HALF_CYC must be at least 1"); end
      if (TAIL_CYC < 1) begin : g_bad_tail  $error("TAIL_CYC must be at least 1"); end
      if (GAP_CYC < 1)  begin : g_bad_gap   $error("GAP_CYC must be at least 1");  end
      if (STRB_CYC < 1) begin : g_bad_strb  $error("STRB_CYC must be at least 1"); end
   endgenerate

   seq_state_t          st;
   logic                imm_q, bcast_q;
   logic [DATA_W-1:0]   b_q;
   logic                accept, start_b, tx_start, tx_fin;
   logic                wait_load, wait_exp;
   logic [WCNT_W-1:0]   wait_len;
   logic [FRAME_W-1:0]  tx_frame;
   logic [ADDR_W-1:0]   addr_first;
   logic                last_frame_fin;

   assign req_ready  = (st == S_IDLE);
   assign accept     = req_valid & req_ready;
   assign addr_first = req_mode[MODE_BCAST_BIT] ? ADDR_BOTH : ADDR_CH_A;
   assign start_b    = (st == S_GAP) && wait_exp;
   assign tx_start   = accept | start_b;
   assign tx_frame   = accept ? {addr_first, req_data_a} : {ADDR_CH_B, b_q};
   assign done       = (st == S_DONE);
   assign last_frame_fin = tx_fin && ((st == S_FRAME_B) || (st == S_FRAME_A && bcast_q));

   always_comb begin
      wait_load = 1'b0;
      wait_len  = GAP_LD;
      if (st == S_FRAME_A && tx_fin && !bcast_q) begin
         wait_load = 1'b1;
         wait_len  = GAP_LD;
      end else if (last_frame_fin && !imm_q) begin
         wait_load = 1'b1;
         wait_len  = STRB_LD;
      end
   end

   dacpair_countdown #(.MAX_LEN(WAIT_MAX)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_len), .expired(wait_exp)
   );

   dacpair_frame_tx #(.FRAME_W(FRAME_W), .HALF_CYC(HALF_CYC), .TAIL_CYC(TAIL_CYC)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .frame(tx_frame), .fin(tx_fin),
      .cs_n(dac_cs_n), .sclk(dac_sclk), .sdi(dac_sdi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         imm_q      <= 1'b0;
         bcast_q    <= 1'b0;
         b_q        <= '0;
         dac_ldac_n <= 1'b1;
      end else begin
         case (st)
            S_IDLE: if (accept) begin
               imm_q      <= req_mode[MODE_IMM_BIT];
               bcast_q    <= req_mode[MODE_BCAST_BIT];
               b_q        <= req_data_b;
               dac_ldac_n <= ~req_mode[MODE_IMM_BIT];
               st         <= S_FRAME_A;
            end
            S_FRAME_A, S_FRAME_B: if (last_frame_fin) begin
               if (imm_q) st <= S_DONE;
               else begin
                  dac_ldac_n <= 1'b0;
                  st         <= S_STROBE;
               end
            end else if (tx_fin) begin
               st <= S_GAP;
            end
            S_GAP:    if (wait_exp) st <= S_FRAME_B;
            S_STROBE: if (wait_exp) begin
               dac_ldac_n <= 1'b1;
               st         <= S_DONE;
            end
            S_DONE: begin
               dac_ldac_n <= 1'b1;
               st         <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dacpair_seq_chk.sv
module dacpair_seq_chk #(
   parameter int HALF_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic done,
   input logic dac_cs_n,
   input logic dac_sclk,
   input logic dac_sdi,
   input logic dac_ldac_n
);
   int hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_run <= 0;
      else if (dac_sclk) hi_run <= hi_run + 1;
      else               hi_run <= 0;
   end

   p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> !dac_cs_n);

   p_sdi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> $stable(dac_sdi));

   p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sclk) |-> (hi_run >= HALF_CYC));

   p_cs_edge_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_cs_n != $past(dac_cs_n)) |-> (!dac_sclk && !$past(dac_sclk)));

   p_ldac_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_ldac_n) |-> dac_cs_n);

   p_ldac_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_ldac_n) |-> $past(dac_cs_n));

   p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_cs_n |-> !req_ready);

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);
endmodule

bind dacpair_seq dacpair_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_ldac_n(dac_ldac_n)
);

// File: tb/dacpair_seq_test.sv
module dacpair_seq_test;
   localparam int DATA_W = 16, HALF_CYC = 2, TAIL_CYC = 2, GAP_CYC = 2, STRB_CYC = 2;
   localparam int FW = DATA_W + 2;

   logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
   logic [1:0] req_mode = 2'b00;
   logic [DATA_W-1:0] req_data_a = '0, req_data_b = '0;
   logic req_ready, done, dac_cs_n, dac_sclk, dac_sdi, dac_ldac_n;

   always #10 clk = ~clk;

   dacpair_seq #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC), .TAIL_CYC(TAIL_CYC),
                 .GAP_CYC(GAP_CYC), .STRB_CYC(STRB_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_data_a(req_data_a), .req_data_b(req_data_b),
      .done(done), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
      .dac_ldac_n(dac_ldac_n));

   int n_chk = 0, n_fail = 0, cyc = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // pin monitor and converter model
   logic p_cs = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0, p_ldac = 1'b1;
   int sclk_run = 100, sdi_age = 100, cs_hi_run = 0, ld_lo_run = 0, last_cs_rise = 0;
   logic [FW-1:0] mon_sr = '0;
   int mon_bits = 0;
   logic [FW-1:0] frm [0:7];
   int frm_bits [0:7];
   int frm_gap [0:7];
   logic frm_ld [0:7];
   logic frm_ld_start [0:7];
   int nf = 0, n_pulse = 0, pulse_w = 0, pulse_setup = 0, n_done = 0;
   logic [DATA_W-1:0] in_a = '0, in_b = '0, out_a = '0, out_b = '0;
   int chg_a = 0, chg_b = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (dac_sdi != p_sdi) sdi_age = 0; else sdi_age++;
         if (dac_sclk != p_sclk) begin
            chk(sclk_run >= HALF_CYC, "R3 serial clock phase width", sclk_run, HALF_CYC);
            if (dac_sclk) begin
               chk(sdi_age >= HALF_CYC, "R3 data setup before rising edge", sdi_age, HALF_CYC);
               if (!dac_cs_n) begin
                  mon_sr = {mon_sr[FW-2:0], dac_sdi};
                  mon_bits++;
               end
            end
            sclk_run = 1;
         end else sclk_run++;

         if (dac_cs_n != p_cs) begin
            chk(!dac_sclk && !p_sclk, "R4 serial clock idle at chip select edge",
                {p_sclk, dac_sclk}, 0);
            if (!dac_cs_n) begin
               mon_bits = 0;
               if (nf < 8) begin
                  frm_gap[nf] = cs_hi_run;
                  frm_ld_start[nf] = dac_ldac_n;
               end
            end else begin
               if (nf < 8) begin
                  frm[nf] = mon_sr;
                  frm_bits[nf] = mon_bits;
                  frm_ld[nf] = dac_ldac_n;
               end
               nf++;
               last_cs_rise = cyc;
               case (mon_sr[FW-1:FW-2])
                  2'b01: in_a = mon_sr[DATA_W-1:0];
                  2'b10: in_b = mon_sr[DATA_W-1:0];
                  2'b11: begin in_a = mon_sr[DATA_W-1:0]; in_b = mon_sr[DATA_W-1:0]; end
                  default: ;
               endcase
            end
         end
         if (dac_cs_n) cs_hi_run++; else cs_hi_run = 0;

         if (dac_ldac_n != p_ldac) begin
            if (!dac_ldac_n) begin
               pulse_setup = cyc - last_cs_rise;
               ld_lo_run = 1;
            end else begin
               n_pulse++;
               pulse_w = ld_lo_run;
            end
         end else if (!dac_ldac_n) ld_lo_run++;

         if (!dac_ldac_n) begin
            if (out_a != in_a) begin out_a = in_a; chg_a = cyc; end
            if (out_b != in_b) begin out_b = in_b; chg_b = cyc; end
         end

         if (!dac_cs_n) chk(!req_ready, "R10 ready low while a frame is on the link", req_ready, 0);
         if (done) begin
            n_done++;
            chk(!req_ready, "R11 ready low during done", req_ready, 0);
         end
      end
      p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdi = dac_sdi; p_ldac = dac_ldac_n;
   end

   task automatic clear_log();
      nf = 0; n_pulse = 0; n_done = 0; pulse_w = 0; pulse_setup = 0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (n_done == 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic run_req(input logic [1:0] mode, input logic [DATA_W-1:0] a, b);
      clear_log();
      req_mode = mode; req_data_a = a; req_data_b = b; req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      wait_done();
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(dac_cs_n && !dac_sclk && dac_ldac_n && !done,
          "R1 link idle during reset", {dac_cs_n, dac_sclk, dac_ldac_n, done}, 4'b1010);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(req_ready && dac_cs_n && !dac_sclk && dac_ldac_n && !done,
          "R1 idle after reset", {req_ready, dac_cs_n, dac_sclk, dac_ldac_n, done}, 5'b11010);
      @(posedge clk); #1;
   endtask

   task automatic t_sync(input logic [DATA_W-1:0] a, b);
      run_req(2'b00, a, b);
      chk(nf == 2, "R5 two frames", nf, 2);
      chk(frm[0] == {2'b01, a}, "R2 R5 channel A frame", frm[0], {2'b01, a});
      chk(frm[1] == {2'b10, b}, "R2 R5 channel B frame", frm[1], {2'b10, b});
      chk(frm_bits[0] == FW && frm_bits[1] == FW, "R2 clocks per frame", frm_bits[0], FW);
      chk(frm_ld[0] && frm_ld[1], "R5 strobe high at chip select rise", {frm_ld[0], frm_ld[1]}, 2'b11);
      chk(n_pulse == 1, "R5 single strobe pulse", n_pulse, 1);
      chk(pulse_w >= STRB_CYC, "R8 strobe width", pulse_w, STRB_CYC);
      chk(pulse_setup >= TAIL_CYC, "R8 strobe after chip select rise", pulse_setup, TAIL_CYC);
      chk(frm_gap[1] >= TAIL_CYC + GAP_CYC, "R9 spacing between frames", frm_gap[1], TAIL_CYC + GAP_CYC);
      chk(out_a == a && out_b == b, "R5 converter outputs", {out_a, out_b}, {a, b});
      chk(chg_a == chg_b && chg_a > last_cs_rise, "R5 outputs change together", chg_a, chg_b);
      chk(n_done == 1, "R11 one done pulse", n_done, 1);
   endtask

   task automatic t_imm(input logic [DATA_W-1:0] a, b);
      run_req(2'b01, a, b);
      chk(nf == 2, "R6 two frames", nf, 2);
      chk(frm[0] == {2'b01, a} && frm[1] == {2'b10, b}, "R6 frame contents", frm[1], {2'b10, b});
      chk(!frm_ld_start[0] && !frm_ld[0] && !frm_ld[1], "R6 strobe held low",
          {frm_ld_start[0], frm_ld[0], frm_ld[1]}, 0);
      chk(n_pulse == 1, "R6 strobe released once, no extra pulse", n_pulse, 1);
      chk(out_a == a && out_b == b, "R6 converter outputs", {out_a, out_b}, {a, b});
      chk(chg_a < chg_b, "R6 channel A updates first", chg_a, chg_b);
      chk(n_done == 1, "R11 one done pulse", n_done, 1);
   endtask

   task automatic t_bcast(input logic [DATA_W-1:0] a, b, input bit imm);
      run_req({1'b1, imm}, a, b);
      chk(nf == 1, "R7 single frame", nf, 1);
      chk(frm[0] == {2'b11, a}, "R7 broadcast frame", frm[0], {2'b11, a});
      chk(frm_bits[0] == FW, "R2 clocks per broadcast frame", frm_bits[0], FW);
      chk(out_a == a && out_b == a, "R7 channel B value ignored", {out_a, out_b}, {a, a});
      chk(chg_a == chg_b, "R7 both outputs change together", chg_a, chg_b);
      chk(frm_ld[0] == !imm, "R7 strobe level at chip select rise", frm_ld[0], !imm);
      chk(n_pulse == 1, "R7 one strobe low period", n_pulse, 1);
      chk(n_done == 1, "R11 one done pulse", n_done, 1);
   endtask

   task automatic t_busy(input logic [DATA_W-1:0] a, b);
      clear_log();
      req_mode = 2'b00; req_data_a = a; req_data_b = b; req_valid = 1'b1;
      @(posedge clk);
      #1 req_mode = 2'b11; req_data_a = 16'hDEAD; req_data_b = 16'hBEEF;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(!req_ready, "R10 ready low while busy", req_ready, 0);
      end
      @(posedge clk); #1 req_valid = 1'b0;
      wait_done();
      chk(nf == 2 && frm[0] == {2'b01, a} && frm[1] == {2'b10, b},
          "R10 request during busy ignored", frm[0], {2'b01, a});
      chk(out_a == a && out_b == b, "R10 outputs from first request", {out_a, out_b}, {a, b});
   endtask

   task automatic t_midreset();
      clear_log();
      req_mode = 2'b00; req_data_a = 16'h7E57; req_data_b = 16'h0BAD; req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      repeat (30) @(posedge clk);
      #1 rst_n = 1'b0;
      #2;
      chk(dac_cs_n && !dac_sclk && dac_ldac_n && req_ready && !done,
          "R1 mid-transaction reset", {dac_cs_n, dac_sclk, dac_ldac_n, req_ready, done}, 5'b10110);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (4) @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_sync(16'hA5C3, 16'h3C5A);
      t_imm(16'h1234, 16'hFEDC);
      t_bcast(16'h8001, 16'h7777, 1'b0);
      t_bcast(16'h0FF0, 16'hAAAA, 1'b1);
      t_sync(16'hFFFF, 16'h0000);
      t_busy(16'h5555, 16'h2AAA);
      t_midreset();
      t_sync(16'h0001, 16'h8000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule